// File: doc/BRIEF.md
# Broadcast Audio Frame Filter with Clock-Domain FIFO

This block sits behind an Ethernet receive path and delivers audio samples to a codec-side consumer. It takes 32-bit words from the MAC receiver on the Ethernet clock. The first four words of each raw frame are compared with a fixed broadcast audio signature. When every header field matches, the following PCM sample words are written into an asynchronous FIFO. The FIFO carries them into the audio clock domain.

A frame that fails any header comparison is thrown away word by word until the MAC signals the end of the packet, either good or bad. Frame tracking needs no state machine. An eleven-bit word counter and a single "frame still acceptable" flag hold the whole position and verdict of the current frame.

On the audio side, the consumer raises a request. Whenever the FIFO holds a word, one word is popped per requesting cycle and presented for exactly one audio clock cycle together with a valid flag.

Top module: `eth_audio_filter`

## Requirements
- R1: After either reset, the output-valid flag is low, no word is delivered, the word count is zero and the frame is treated as acceptable.
- R2: Header words must equal, in arrival order, 0xFFFFFFFF, 0xFFFF0090, 0xC2001C50, and a word whose bits [31:16] are 0x0101. Any mismatch prevents every word of that frame from reaching the audio side.
- R3: Bits [15:0] of the fourth header word are not compared, so any value there still lets the frame through.
- R4: Only words from the fifth word of a frame onward are forwarded. Header words are never forwarded, and sample words leave in arrival order.
- R5: The word count saturates at 1028, so at most 1024 sample words of one frame are forwarded and any later words are dropped.
- R6: A good-end or bad-end pulse clears the word count and marks the next frame acceptable. A word strobed in the same cycle as an end pulse belongs to the frame that is ending.
- R7: The FIFO holds 16 words by default. A sample word that arrives while the FIFO is full is dropped, and the words already stored are left intact.
- R8: A request sampled while the FIFO is non-empty pops one word. The output-valid flag is high for exactly the following audio cycle, with that word on the data output.
- R9: A request sampled while the FIFO is empty, or a cycle without a request, leaves output-valid low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| eth_clk | input | 1 | Ethernet receive clock |
| eth_rst_n | input | 1 | Active-low reset, Ethernet domain |
| rx_data | input | 32 | Word from the MAC receiver |
| rx_valid | input | 1 | rx_data carries a word this cycle |
| rx_end_good | input | 1 | Pulse: frame ended with good CRC |
| rx_end_bad | input | 1 | Pulse: frame ended with bad CRC |
| aud_clk | input | 1 | Audio clock |
| aud_rst_n | input | 1 | Active-low reset, audio domain |
| aud_req | input | 1 | Consumer asks for a sample word |
| aud_data | output | 32 | Sample word to the consumer |
| aud_valid | output | 1 | aud_data holds a freshly popped word |

## Verification
The functions that can coincide are the word strobe and the end-of-packet pulse. When the MAC marks the last sample word with an end pulse in the same cycle, that word must still be judged and forwarded under the ending frame, while the counter and acceptance flag restart for the next frame. The bench sends a good frame whose fifth sample word carries the end pulse and follows it at once with a second good frame. It then judges the outcome by the exact sequence of eight sample words that reach the audio side, with no header word among them.

// File: rtl/eaf_pkg.sv
package eaf_pkg;

  localparam int DATA_W    = 32;
  localparam int HDR_WORDS = 4;

  localparam logic [31:0] SIG_W0 = 32'hFFFF_FFFF;
  localparam logic [31:0] SIG_W1 = 32'hFFFF_0090;
  localparam logic [31:0] SIG_W2 = 32'hC200_1C50;
  localparam logic [15:0] SIG_TYPE = 16'h0101;

  // compare one header word against the broadcast audio signature
  function automatic logic hdr_match(input logic [1:0] idx, input logic [31:0] w);
    logic ok;
    case (idx)
      2'd0:    ok = (w == SIG_W0);
      2'd1:    ok = (w == SIG_W1);
      2'd2:    ok = (w == SIG_W2);
      default: ok = (w[31:16] == SIG_TYPE);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/eaf_rst_sync.sv
module eaf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign rst_n_sync = stage[1];
endmodule

// File: rtl/eaf_sync2.sv
module eaf_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eaf_frame_tracker.sv
module eaf_frame_tracker
  import eaf_pkg::*;
#(
  parameter int FRAME_WORDS = 1028,
  localparam int CNT_W = $clog2(FRAME_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              end_good,
  input  logic              end_bad,
  output logic              wr_req,
  output logic [CNT_W-1:0]  word_cnt,
  output logic              frame_ok
);
  localparam logic [CNT_W-1:0] HDR_LIM   = CNT_W'(HDR_WORDS);
  localparam logic [CNT_W-1:0] FRAME_LIM = CNT_W'(FRAME_WORDS);

  logic             pkt_end;
  logic             in_hdr;
  logic             in_pay;
  logic             hdr_bad;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_nxt;
  logic             ok_nxt;

  always_comb begin
    pkt_end = end_good | end_bad;
    in_hdr  = (word_cnt < HDR_LIM);
    in_pay  = (word_cnt >= HDR_LIM) && (word_cnt < FRAME_LIM);
    hdr_bad = rx_valid && in_hdr && !hdr_match(word_cnt[1:0], rx_data);
    wr_req  = rx_valid && in_pay && frame_ok;

    cnt_en  = pkt_end | rx_valid;
    cnt_nxt = word_cnt;
    ok_nxt  = frame_ok;
    if (pkt_end) begin
      cnt_nxt = '0;
      ok_nxt  = 1'b1;
    end else begin
      if (rx_valid && (word_cnt != FRAME_LIM)) cnt_nxt = word_cnt + 1'b1;
      if (hdr_bad) ok_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_cnt <= '0;
      frame_ok <= 1'b1;
    end else if (cnt_en) begin
      word_cnt <= cnt_nxt;
      frame_ok <= ok_nxt;
    end
  end
endmodule

// File: rtl/eaf_async_fifo.sv
module eaf_async_fifo #(
  parameter int DW = 32,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_push,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, wbin_nxt, wgray_nxt;
  logic [AW:0] rbin, rgray, rbin_nxt, rgray_nxt;
  logic [AW:0] rgray_w, wgray_r;
  logic        rd_pop;

  // write domain
  always_comb begin
    full      = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    wr_push   = wr_en & ~full;
    wbin_nxt  = wbin + {{AW{1'b0}}, wr_push};
    wgray_nxt = (wbin_nxt >> 1) ^ wbin_nxt;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_push) begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_push) mem[wbin[AW-1:0]] <= wr_data;
  end

  eaf_sync2 #(.W(AW + 1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
  );

  // read domain
  always_comb begin
    empty     = (rgray == wgray_r);
    rd_pop    = rd_en & ~empty;
    rbin_nxt  = rbin + {{AW{1'b0}}, rd_pop};
    rgray_nxt = (rbin_nxt >> 1) ^ rbin_nxt;
    rd_data   = mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_pop) begin
      rbin  <= rbin_nxt;
      rgray <= rgray_nxt;
    end
  end

  eaf_sync2 #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
  );
endmodule

// File: rtl/eaf_out_port.sv
module eaf_out_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          empty,
  input  logic [DW-1:0] rd_data,
  output logic          rd_en,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  logic valid_nxt;

  always_comb begin
    rd_en     = req & ~empty;
    valid_nxt = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_data <= '0;
    else if (rd_en) out_data <= rd_data;
  end
endmodule

// File: rtl/eth_audio_filter.sv
module eth_audio_filter
  import eaf_pkg::*;
#(
  parameter int FRAME_WORDS = 1028,
  parameter int FIFO_AW     = 4,
  localparam int CNT_W = $clog2(FRAME_WORDS + 1)
) (
  input  logic              eth_clk,
  input  logic              eth_rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_end_good,
  input  logic              rx_end_bad,
  input  logic              aud_clk,
  input  logic              aud_rst_n,
  input  logic              aud_req,
  output logic [DATA_W-1:0] aud_data,
  output logic              aud_valid
);
  logic              eth_rst_s, aud_rst_s;
  logic              fifo_wr_req, fifo_push, fifo_full;
  logic [CNT_W-1:0]  word_cnt;
  logic              frame_ok;
  logic              rd_en, rd_empty;
  logic [DATA_W-1:0] rd_data;

  eaf_rst_sync u_eth_rst (.clk(eth_clk), .rst_n(eth_rst_n), .rst_n_sync(eth_rst_s));
  eaf_rst_sync u_aud_rst (.clk(aud_clk), .rst_n(aud_rst_n), .rst_n_sync(aud_rst_s));

  eaf_frame_tracker #(.FRAME_WORDS(FRAME_WORDS)) u_track (
    .clk(eth_clk), .rst_n(eth_rst_s),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .end_good(rx_end_good), .end_bad(rx_end_bad),
    .wr_req(fifo_wr_req), .word_cnt(word_cnt), .frame_ok(frame_ok)
  );

  eaf_async_fifo #(.DW(DATA_W), .AW(FIFO_AW)) u_fifo (
    .wclk(eth_clk), .wrst_n(eth_rst_s),
    .wr_en(fifo_wr_req), .wr_data(rx_data),
    .wr_push(fifo_push), .full(fifo_full),
    .rclk(aud_clk), .rrst_n(aud_rst_s),
    .rd_en(rd_en), .rd_data(rd_data), .empty(rd_empty)
  );

  eaf_out_port #(.DW(DATA_W)) u_out (
    .clk(aud_clk), .rst_n(aud_rst_s),
    .req(aud_req), .empty(rd_empty), .rd_data(rd_data),
    .rd_en(rd_en), .out_data(aud_data), .out_valid(aud_valid)
  );
endmodule

// File: rtl/eaf_checker.sv
module eaf_checker #(
  parameter int FRAME_WORDS = 1028,
  localparam int CNT_W = $clog2(FRAME_WORDS + 1)
) (
  input logic             eth_clk,
  input logic             eth_rst_n,
  input logic             aud_clk,
  input logic             aud_rst_n,
  input logic [31:0]      rx_data,
  input logic             rx_valid,
  input logic             rx_end_good,
  input logic             rx_end_bad,
  input logic [CNT_W-1:0] word_cnt,
  input logic             frame_ok,
  input logic             fifo_push,
  input logic             fifo_full,
  input logic             rd_en,
  input logic [31:0]      rd_data,
  input logic [31:0]      aud_data,
  input logic             aud_valid
);
  localparam logic [CNT_W-1:0] FRAME_LIM = CNT_W'(FRAME_WORDS);
  localparam logic [CNT_W-1:0] HDR_LIM   = CNT_W'(4);

  // R5
  cnt_sat_chk: assert property (@(posedge eth_clk) disable iff (!eth_rst_n)
    word_cnt <= FRAME_LIM);

  // R6
  end_restart_chk: assert property (@(posedge eth_clk) disable iff (!eth_rst_n)
    (rx_end_good || rx_end_bad) |=> (word_cnt == '0) && frame_ok);

  // R2
  hdr_kill_chk: assert property (@(posedge eth_clk) disable iff (!eth_rst_n)
    (rx_valid && word_cnt == '0 && rx_data != 32'hFFFF_FFFF && !rx_end_good && !rx_end_bad)
      |=> !frame_ok);

  // R4
  pay_only_chk: assert property (@(posedge eth_clk) disable iff (!eth_rst_n)
    fifo_push |-> (word_cnt >= HDR_LIM) && (word_cnt < FRAME_LIM));

  // R7
  no_overflow_chk: assert property (@(posedge eth_clk) disable iff (!eth_rst_n)
    fifo_full |-> !fifo_push);

  // R8
  pop_valid_chk: assert property (@(posedge aud_clk) disable iff (!aud_rst_n)
    rd_en |=> aud_valid && (aud_data == $past(rd_data)));

  // R9
  idle_quiet_chk: assert property (@(posedge aud_clk) disable iff (!aud_rst_n)
    !rd_en |=> !aud_valid);
endmodule

bind eth_audio_filter eaf_checker #(.FRAME_WORDS(FRAME_WORDS)) u_chk (
  .eth_clk(eth_clk), .eth_rst_n(eth_rst_n), .aud_clk(aud_clk), .aud_rst_n(aud_rst_n),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_end_good(rx_end_good), .rx_end_bad(rx_end_bad),
  .word_cnt(word_cnt), .frame_ok(frame_ok), .fifo_push(fifo_push), .fifo_full(fifo_full),
  .rd_en(rd_en), .rd_data(rd_data), .aud_data(aud_data), .aud_valid(aud_valid)
);

// File: tb/eth_audio_filter_test.sv
`timescale 1ns/1ps
module eth_audio_filter_test;
  logic        eth_clk = 0, aud_clk = 0;
  logic        eth_rst_n = 0, aud_rst_n = 0;
  logic [31:0] rx_data = 0;
  logic        rx_valid = 0, rx_end_good = 0, rx_end_bad = 0;
  logic        aud_req = 0;
  logic [31:0] aud_data;
  logic        aud_valid;

  int checks = 0, errors = 0;
  int ncap = 0;
  logic [31:0] cap [2048];
  bit done = 0;

  always #5   eth_clk = ~eth_clk;
  always #3.5 aud_clk = ~aud_clk;

  eth_audio_filter uut (
    .eth_clk(eth_clk), .eth_rst_n(eth_rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_end_good(rx_end_good), .rx_end_bad(rx_end_bad), .aud_clk(aud_clk),
    .aud_rst_n(aud_rst_n), .aud_req(aud_req), .aud_data(aud_data), .aud_valid(aud_valid)
  );

  always @(negedge aud_clk) begin
    if (aud_valid === 1'b1) begin
      if (ncap < 2048) cap[ncap] = aud_data;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic word(input logic [31:0] d, input bit eg = 0, input bit eb = 0);
    @(negedge eth_clk);
    rx_valid = 1; rx_data = d; rx_end_good = eg; rx_end_bad = eb;
  endtask

  task automatic idle();
    @(negedge eth_clk);
    rx_valid = 0; rx_end_good = 0; rx_end_bad = 0;
  endtask

  task automatic end_pulse(input bit good);
    @(negedge eth_clk);
    rx_valid = 0; rx_end_good = good; rx_end_bad = !good;
    @(negedge eth_clk);
    rx_end_good = 0; rx_end_bad = 0;
  endtask

  // bad_idx selects a corrupted header word (4 = none)
  task automatic header(input logic [15:0] pad, input int bad_idx = 4);
    word(bad_idx == 0 ? 32'hFFFF_FFFE : 32'hFFFF_FFFF);
    word(bad_idx == 1 ? 32'hFFFF_0091 : 32'hFFFF_0090);
    word(bad_idx == 2 ? 32'hC200_1C51 : 32'hC200_1C50);
    word({(bad_idx == 3 ? 16'h0102 : 16'h0101), pad});
  endtask

  task automatic settle();
    idle();
    repeat (60) @(negedge eth_clk);
  endtask

  task automatic expect_run(input string req, input int start, input int n, input logic [31:0] base);
    chk(ncap - start == n, req, ncap - start, n);
    for (int i = 0; i < n && start + i < ncap && start + i < 2048; i++)
      chk(cap[start + i] == base + i, req, cap[start + i], base + i);
  endtask

  task automatic t_reset();
    int s = ncap;
    chk(aud_valid === 1'b0, "R1", aud_valid, 0);
    aud_req = 1;
    repeat (10) @(negedge aud_clk);
    chk(ncap == s, "R1/R9 request while empty", ncap - s, 0);
  endtask

  task automatic t_good();
    int s = ncap;
    header(16'h1234);
    for (int i = 0; i < 40; i++) word(32'hA000_0000 + i);
    end_pulse(1);
    settle();
    expect_run("R4", s, 40, 32'hA000_0000);
  endtask

  task automatic t_pad();
    int s = ncap;
    header(16'hBEEF);
    for (int i = 0; i < 8; i++) word(32'hB000_0000 + i);
    end_pulse(1);
    settle();
    expect_run("R3", s, 8, 32'hB000_0000);
  endtask

  task automatic t_bad();
    int s;
    for (int k = 0; k < 4; k++) begin
      s = ncap;
      header(16'h0000, k);
      for (int i = 0; i < 8; i++) word(32'hC000_0000 + i);
      end_pulse(0);
      settle();
      chk(ncap == s, "R2 corrupted header word", ncap - s, 0);
    end
    s = ncap;
    header(16'h0000);
    for (int i = 0; i < 4; i++) word(32'hC100_0000 + i);
    end_pulse(1);
    settle();
    expect_run("R6 after bad frame", s, 4, 32'hC100_0000);
  endtask

  task automatic t_sat();
    int s = ncap;
    header(16'h0001);
    for (int i = 0; i < 1030; i++) word(32'hD000_0000 + i);
    end_pulse(1);
    settle();
    expect_run("R5", s, 1024, 32'hD000_0000);
  endtask

  task automatic t_end_same();
    int s = ncap;
    header(16'h0002);
    for (int i = 0; i < 4; i++) word(32'hE000_0000 + i);
    word(32'hE000_0004, 1, 0);
    header(16'h0003);
    for (int i = 5; i < 8; i++) word(32'hE000_0000 + i);
    end_pulse(1);
    settle();
    expect_run("R6 end with word", s, 8, 32'hE000_0000);
  endtask

  task automatic t_full();
    int s = ncap;
    aud_req = 0;
    header(16'h0004);
    for (int i = 0; i < 20; i++) word(32'hF000_0000 + i);
    end_pulse(1);
    settle();
    chk(ncap == s, "R9 no request", ncap - s, 0);
    aud_req = 1;
    settle();
    expect_run("R7", s, 16, 32'hF000_0000);
  endtask

  task automatic t_pulse();
    int s;
    aud_req = 0;
    header(16'h0005);
    for (int i = 0; i < 3; i++) word(32'h1200_0000 + i);
    end_pulse(1);
    settle();
    s = ncap;
    for (int p = 0; p < 2; p++) begin
      @(negedge aud_clk); aud_req = 1;
      @(negedge aud_clk); aud_req = 0;
      repeat (5) @(negedge aud_clk);
    end
    expect_run("R8 one word per pulse", s, 2, 32'h1200_0000);
    aud_req = 1;
    settle();
    expect_run("R8 drain", s, 3, 32'h1200_0000);
  endtask

  initial begin
    repeat (4) @(negedge eth_clk);
    eth_rst_n = 1; aud_rst_n = 1;
    repeat (6) @(negedge eth_clk);
    t_reset();
    t_good();
    t_pad();
    t_bad();
    t_sat();
    t_end_same();
    t_full();
    t_pulse();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule